// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a compact SPI master that a processor drives through a 16-bit register port. Software sets up a control word (enable, word width, serial clock polarity and sampling edge, clock divider, interrupt enables). A write to the data register then starts a serial exchange. In byte mode one byte is exchanged. In word mode two bytes go out back to back, upper byte first. The bits shifted in from the serial input replace the contents of the data register when the exchange ends.

Two status flags report progress: an engine-busy flag and a received-data flag. The received-data flag is acknowledged by reading the data register. One level-sensitive interrupt line combines the two flags under separate enables and is gated by the module enable. The bus port is a single-cycle synchronous strobe interface with combinational read data and no wait states.

Top module: `spi_host`

## Requirements
- R1: After reset the data, control and status registers read 0x0000, the interrupt output is low and the serial clock is low.
- R2: The register offsets are data 0x0, control 0x2 and status 0x4. The control register reads back what was written. A write to the status register has no effect. Any other offset reads 0x0000, and a write to it changes nothing.
- R3: A data-register write starts an exchange only when the enable bit (control bit 0) is 1 and the engine is idle. Status bit 0 (busy) then reads 1 from the next cycle on. A data write while busy or while disabled neither starts nor restarts an exchange.
- R4: The serial clock toggles once every (divider+1) system cycles, where the divider is control bits 15:9. It makes 16 toggles per byte. While idle it sits at the level of control bit 8.
- R5: When control bit 7 is 0, the input is sampled on the first edge of each bit and the output changes on the second edge. When bit 7 is 1 this is reversed. Bits travel most significant first.
- R6: When control bit 2 is 1 (word mode), the upper byte is sent first, then the lower byte, and the first received byte lands in bits 15:8. When bit 2 is 0, only the lower byte is sent, and the received byte lands in bits 7:0 with bits 15:8 zero.
- R7: An exchange ends 16 x bytes x (divider+1) cycles after the starting write. In that same cycle busy clears and status bit 1 (received-data) sets.
- R8: A data-register read returns the captured word and clears the received-data flag. If completion falls on the same cycle as the read, completion wins.
- R9: The interrupt output is high only while enabled. It is high when busy is clear and control bit 6 is 1, or when received-data is set and control bit 5 is 1. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A register write takes effect at the strobe edge. Control-dependent outputs (interrupt, idle clock level) are therefore compared one nanosecond after that edge. Busy reads back as 1 in the first read after the starting write. The completion flags change exactly 16 x bytes x (divider+1) edges after the write. The bench places one status read just before that edge and one just after it, so an early or late finish is caught. Read data is compared half a cycle before the strobe edge, against a behavioural model that counts serial edges from elapsed cycles. The same model decides on which edges the serial input must be valid and where the serial output is captured.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 7;
  localparam int EDGES  = 2 * BYTE_W;
  localparam int EDGE_W = $clog2(EDGES);

  localparam int OFF_DATA = 0;
  localparam int OFF_CTRL = 2;
  localparam int OFF_STAT = 4;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             idle_hi;
    logic             late_sample;
    logic             done_ie;
    logic             rx_ie;
    logic [1:0]       rsv_b;
    logic             wide;
    logic             rsv_a;
    logic             en;
  } ctrl_t;

  // Even edge index is the leading edge of a bit.
  function automatic logic is_sample_edge(input logic [EDGE_W-1:0] idx, input logic late);
    return idx[0] == late;
  endfunction

  function automatic logic [BYTE_W-1:0] first_byte(input logic [WORD_W-1:0] w, input logic wide);
    return wide ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] pack_rx(input logic [WORD_W-1:0] acc, input logic wide);
    return wide ? acc : {{(WORD_W-BYTE_W){1'b0}}, acc[BYTE_W-1:0]};
  endfunction

  function automatic logic irq_level(input ctrl_t c, input logic busy, input logic rbf);
    return c.en && ((!busy && c.done_ie) || (rbf && c.rx_ie));
  endfunction
endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              busy,
  input  logic              done_evt,
  input  logic [WORD_W-1:0] cap_word,
  output ctrl_t             ctrl,
  output logic              rbf,
  output logic              data_wr,
  output logic              data_rd,
  output logic [WORD_W-1:0] bus_rdata
);
  logic hit_data, hit_ctrl, hit_stat;
  logic [WORD_W-1:0] data_q;
  ctrl_t ctrl_q;
  logic  rbf_q;

  assign hit_data = (bus_addr == ADDR_W'(OFF_DATA));
  assign hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
  assign data_wr  = bus_wr && hit_data;
  assign data_rd  = bus_rd && hit_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      rbf_q  <= 1'b0;
    end else begin
      if (bus_wr && hit_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
      if (done_evt) begin
        data_q <= cap_word;
        rbf_q  <= 1'b1;
      end else if (data_rd) begin
        rbf_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_data)      bus_rdata = data_q;
      else if (hit_ctrl) bus_rdata = WORD_W'(ctrl_q);
      else if (hit_stat) bus_rdata = {{(WORD_W-2){1'b0}}, rbf_q, busy};
    end
  end

  assign ctrl = ctrl_q;
  assign rbf  = rbf_q;
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic              kick,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              sclk_raw,
  output logic              mosi,
  output logic              start_evt,
  output logic              done_evt,
  output logic [WORD_W-1:0] cap_word
);
  logic              busy_q, sclk_q, mosi_q, second_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [EDGE_W-1:0] edge_q;
  logic [BYTE_W-1:0] tx_sh_q, lo_q, fb;
  logic [WORD_W-1:0] acc_q, acc_nx;
  logic tick, sample_evt, shift_evt, last_edge;

  assign fb         = first_byte(tx_word, ctrl.wide);
  assign tick       = busy_q && (cnt_q == ctrl.div);
  assign sample_evt = tick && is_sample_edge(edge_q, ctrl.late_sample);
  assign shift_evt  = tick && !sample_evt;
  assign last_edge  = tick && (edge_q == EDGE_W'(EDGES - 1));
  assign done_evt   = last_edge && !second_q;
  assign start_evt  = kick && ctrl.en && !busy_q;
  assign acc_nx     = sample_evt ? {acc_q[WORD_W-2:0], miso} : acc_q;
  assign cap_word   = pack_rx(acc_nx, ctrl.wide);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      second_q <= 1'b0;
      cnt_q    <= '0;
      edge_q   <= '0;
      tx_sh_q  <= '0;
      lo_q     <= '0;
      acc_q    <= '0;
    end else if (start_evt) begin
      busy_q   <= 1'b1;
      cnt_q    <= '0;
      edge_q   <= '0;
      sclk_q   <= ctrl.idle_hi;
      second_q <= ctrl.wide;
      lo_q     <= tx_word[BYTE_W-1:0];
      acc_q    <= '0;
      if (!ctrl.late_sample) begin
        mosi_q  <= fb[BYTE_W-1];
        tx_sh_q <= {fb[BYTE_W-2:0], 1'b0};
      end else begin
        tx_sh_q <= fb;
      end
    end else if (busy_q) begin
      acc_q <= acc_nx;
      if (tick) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 1'b1;
        if (shift_evt) begin
          mosi_q  <= tx_sh_q[BYTE_W-1];
          tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b0};
        end
        if (last_edge) begin
          edge_q <= '0;
          if (second_q) begin
            second_q <= 1'b0;
            if (!ctrl.late_sample) begin
              mosi_q  <= lo_q[BYTE_W-1];
              tx_sh_q <= {lo_q[BYTE_W-2:0], 1'b0};
            end else begin
              tx_sh_q <= lo_q;
            end
          end else begin
            busy_q <= 1'b0;
          end
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign sclk_raw = sclk_q;
  assign mosi     = mosi_q;
endmodule

// File: rtl/spi_host_irq.sv
module spi_host_irq
  import spi_host_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  busy,
  input  logic  rbf,
  output logic  irq
);
  assign irq = irq_level(ctrl, busy, rbf);
endmodule

// File: rtl/spi_host.sv
module spi_host
  import spi_host_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  ctrl_t ctrl;
  logic busy, rbf, data_wr, data_rd, start_evt, done_evt, sclk_raw;
  logic ctrl_en, ctrl_idle_hi, ctrl_rx_ie;
  logic [WORD_W-1:0] cap_word;

  spi_host_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .busy(busy), .done_evt(done_evt),
    .cap_word(cap_word), .ctrl(ctrl), .rbf(rbf), .data_wr(data_wr),
    .data_rd(data_rd), .bus_rdata(bus_rdata)
  );

  spi_host_engine u_engine (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .kick(data_wr), .tx_word(bus_wdata),
    .miso(miso), .busy(busy), .sclk_raw(sclk_raw), .mosi(mosi),
    .start_evt(start_evt), .done_evt(done_evt), .cap_word(cap_word)
  );

  spi_host_irq u_irq (.ctrl(ctrl), .busy(busy), .rbf(rbf), .irq(irq));

  assign ctrl_en      = ctrl.en;
  assign ctrl_idle_hi = ctrl.idle_hi;
  assign ctrl_rx_ie   = ctrl.rx_ie;
  assign sclk         = busy ? sclk_raw : ctrl.idle_hi;
endmodule

// File: rtl/spi_host_checker.sv
module spi_host_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic rbf,
  input logic en,
  input logic idle_hi,
  input logic rx_ie,
  input logic irq,
  input logic sclk_raw,
  input logic data_wr,
  input logic data_rd,
  input logic done_evt
);
  // R3: busy only rises after an enabled data write
  p_start_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(data_wr && en));

  // R7: completion leaves engine idle with data flagged
  p_done_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (rbf && !busy));

  // R4: after the final toggle the clock is back at its idle level
  p_done_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (sclk_raw == $past(idle_hi)));

  // R8: data read acknowledges unless completion lands together
  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !done_evt) |=> !rbf);

  // R9: no interrupt while disabled
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);

  // R9: received-data source raises the line
  p_irq_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rbf && rx_ie) |-> irq);
endmodule

bind spi_host spi_host_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rbf(rbf), .en(ctrl_en),
  .idle_hi(ctrl_idle_hi), .rx_ie(ctrl_rx_ie), .irq(irq), .sclk_raw(sclk_raw),
  .data_wr(data_wr), .data_rd(data_rd), .done_evt(done_evt)
);

// File: tb/spi_host_test.sv
`timescale 1ns/1ps
module spi_host_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, sclk, mosi;
  logic        miso = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spi_host uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // ---------------- reference model ----------------
  logic [15:0] m_data, m_ctrl, m_rx, m_mosi, m_mosi_last, slave_word;
  logic        m_busy, m_rbf, m_sclk, m_done, m_was_busy;
  int          m_elapsed, m_nb, m_samples, m_h, m_e;

  function automatic logic samp(int e, logic late);
    // edge number e counts from 1; odd numbers are leading edges
    return ((e % 2) == 1) == (late == 1'b0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = 0; m_ctrl = 0; m_rx = 0; m_mosi = 0; m_mosi_last = 0;
      m_busy = 0; m_rbf = 0; m_sclk = 0; m_elapsed = 0; m_nb = 1; m_samples = 0;
    end else begin
      m_done = 0;
      m_was_busy = m_busy;
      m_h = int'(m_ctrl[15:9]) + 1;
      if (m_busy) begin
        m_elapsed++;
        if (m_elapsed % m_h == 0) begin
          m_e = m_elapsed / m_h;
          m_sclk = ~m_sclk;
          if (samp(m_e, m_ctrl[7])) begin
            m_rx = {m_rx[14:0], miso};
            m_mosi = {m_mosi[14:0], mosi};
            m_samples++;
          end
          if (m_e == 16 * m_nb) begin
            m_done = 1; m_busy = 0; m_rbf = 1;
            m_data = (m_nb == 2) ? m_rx : {8'h00, m_rx[7:0]};
            m_mosi_last = m_mosi;
          end
        end
      end
      if (bus_rd && bus_addr == 12'h000 && !m_done) m_rbf = 0;
      if (bus_wr && bus_addr == 12'h002) m_ctrl = bus_wdata;
      else if (bus_wr && bus_addr == 12'h000 && m_ctrl[0] && !m_was_busy) begin
        m_busy = 1; m_elapsed = 0; m_nb = m_ctrl[2] ? 2 : 1;
        m_rx = 0; m_mosi = 0; m_samples = 0; m_sclk = m_ctrl[8];
      end
    end
  end

  // slave drives the bit due at the next sampling edge
  always @(negedge clk) begin
    if (m_busy && m_samples < 8 * m_nb)
      miso <= slave_word[8 * m_nb - 1 - m_samples];
  end

  function automatic logic [15:0] model_read(logic [11:0] a);
    if (a == 12'h000) return m_data;
    if (a == 12'h002) return m_ctrl;
    if (a == 12'h004) return {14'h0, m_rbf, m_busy};
    return 16'h0;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous R4 / R9 comparison one ns after each edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R4 sclk", {15'h0, sclk}, {15'h0, m_busy ? m_sclk : m_ctrl[8]});
      chk("R9 irq", {15'h0, irq},
          {15'h0, m_ctrl[0] && ((!m_busy && m_ctrl[6]) || (m_rbf && m_ctrl[5]))});
    end
  end

  task automatic wr(logic [11:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, string tag, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    v = bus_rdata;
    chk(tag, v, model_read(a));
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    slave_word = 16'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(12'h000, "R1 data", v); chk("R1 data zero", v, 16'h0);
    rd(12'h002, "R1 ctrl", v); chk("R1 ctrl zero", v, 16'h0);
    rd(12'h004, "R1 stat", v); chk("R1 stat zero", v, 16'h0);
    chk("R1 irq low", {15'h0, irq}, 16'h0);
    chk("R1 sclk low", {15'h0, sclk}, 16'h0);

    // byte mode, leading-edge sampling, divider 1
    wr(12'h002, 16'h0201);
    rd(12'h002, "R2 ctrl readback", v); chk("R2 ctrl value", v, 16'h0201);
    slave_word = 16'h003C;
    wr(12'h000, 16'h12A5);
    rd(12'h004, "R3 busy", v); chk("R3 busy set", v, 16'h0001);
    wait_idle();
    rd(12'h004, "R7 stat", v); chk("R7 done flags", v, 16'h0002);
    rd(12'h000, "R8 data", v); chk("R6 byte rx", v, 16'h003C);
    rd(12'h004, "R8 stat", v); chk("R8 cleared", v, 16'h0000);
    chk("R5 mosi byte", m_mosi_last, 16'h00A5);

    // word mode, trailing-edge sampling, idle high, divider 2: exact finish
    wr(12'h002, 16'h0585);
    slave_word = 16'h5AC3;
    wr(12'h000, 16'hBEEF);
    repeat (32 * 3 - 1) @(posedge clk);
    rd(12'h004, "R7 before", v); chk("R7 still busy", v, 16'h0001);
    rd(12'h004, "R7 after", v);  chk("R7 finished", v, 16'h0002);
    rd(12'h000, "R6 word", v);   chk("R6 word rx", v, 16'h5AC3);
    chk("R6 mosi word", m_mosi_last, 16'hBEEF);

    // write while busy is ignored
    wr(12'h002, 16'h0601);
    slave_word = 16'h0081;
    wr(12'h000, 16'h0042);
    repeat (10) @(posedge clk);
    wr(12'h000, 16'h00FF);
    repeat (64 - 12) @(posedge clk);
    rd(12'h004, "R3 no restart", v); chk("R3 busy kept", v, 16'h0001);
    rd(12'h004, "R3 end", v);        chk("R3 original end", v, 16'h0002);
    rd(12'h000, "R3 data", v);       chk("R3 data", v, 16'h0081);
    chk("R3 mosi original", m_mosi_last, 16'h0042);

    // disabled: data write ignored
    wr(12'h002, 16'h0200);
    wr(12'h000, 16'h0055);
    repeat (5) @(posedge clk);
    rd(12'h004, "R3 disabled", v); chk("R3 no start", v, 16'h0000);

    // status read-only, unmapped offsets
    wr(12'h004, 16'hFFFF);
    rd(12'h004, "R2 stat ro", v); chk("R2 stat unchanged", v, 16'h0000);
    wr(12'h006, 16'h1234);
    wr(12'h100, 16'hFFFF);
    rd(12'h002, "R2 ctrl kept", v); chk("R2 ctrl unchanged", v, 16'h0200);
    rd(12'h006, "R2 hole", v);      chk("R2 hole zero", v, 16'h0000);
    rd(12'h001, "R2 odd", v);       chk("R2 odd zero", v, 16'h0000);

    // interrupt sources
    wr(12'h002, 16'h0041);
    chk("R9 idle irq", {15'h0, irq}, 16'h0001);
    wr(12'h002, 16'h0040);
    chk("R9 gated", {15'h0, irq}, 16'h0000);
    wr(12'h002, 16'h0021);
    slave_word = 16'h00F0;
    wr(12'h000, 16'h000F);
    chk("R9 busy no irq", {15'h0, irq}, 16'h0000);
    wait_idle();
    chk("R9 rx irq", {15'h0, irq}, 16'h0001);
    rd(12'h000, "R8 div0 data", v); chk("R8 div0 rx", v, 16'h00F0);
    #1 chk("R9 ack drops irq", {15'h0, irq}, 16'h0000);
    chk("R5 div0 mosi", m_mosi_last, 16'h000F);

    // word mode, leading edge, divider 0
    wr(12'h002, 16'h0005);
    slave_word = 16'hA55A;
    wr(12'h000, 16'h3C96);
    wait_idle();
    rd(12'h000, "R6 fast word", v); chk("R6 fast rx", v, 16'hA55A);
    chk("R6 fast mosi", m_mosi_last, 16'h3C96);

    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule